// File: doc/BRIEF.md
# Reed-Solomon Symbol-to-Byte Corrector

This block sits after a Reed-Solomon decoder that works on 12-bit symbols and repairs a page held in a byte-wide, single-port buffer. The page is 2112 bytes long: 2048 bytes of payload, then 64 spare bytes. Symbols are packed into the byte stream so that each symbol takes a byte and a half. The decoder hands over up to four error locations, each a symbol position with a 12-bit error value. The block works out which one or two bytes each location touches and which bits of them flip. It then patches the buffer with a read cycle followed by a write cycle per byte, and ends with a one-cycle done pulse. The pulse carries either the number of symbols repaired or a failure flag.

Correction starts only when the caller's ECC-error qualifier is high. With the qualifier low, the block reports zero repairs at once and leaves the buffer alone. Locations are applied in the order given. Once a location proves uncorrectable, the block still steps through the remaining locations but writes nothing more. A small side path splits each 32-bit syndrome status word into its two 12-bit syndromes for the decoder.

Top module: `rs_symbol_fixer`

## Requirements
- R1: Position 0 with error bits 11:8 all zero flips page byte 0 by error bits 7:0 and touches no other byte.
- R2: Position 0 with any of error bits 11:8 set is uncorrectable: fail is reported and no byte is written.
- R3: An odd position p with b = floor(3p/2) flips byte b by error bits 11:4, and flips byte b+1 by error bits 3:0 placed in bits 7:4.
- R4: An even nonzero position p with b = 3p/2 flips byte b-1 by error bits 11:8 placed in bits 3:0, and flips byte b by error bits 7:0.
- R5: Position 1365 straddles the payload/spare edge: byte 2047 takes error bits 11:4 and byte 2048 (spare byte 0) takes error bits 3:0 in its upper nibble.
- R6: Positions 1366 to 1374 land in the spare area under the R3/R4 rules, using page byte indices 2048 and above. The highest position, 1374, touches bytes 2060 and 2061.
- R7: Any position above 1374 is uncorrectable and forces fail.
- R8: Locations are processed in order. Those ahead of a failing location stay applied. Those behind it cause no write. When fail is set the reported count is 0.
- R9: Completion is a single-cycle done pulse. Without a failure, the count equals the number of locations given (0 to 4).
- R10: With the ECC qualifier low at start, done follows on the next cycle with count 0, fail 0 and no memory access.
- R11: Each patched byte uses a read cycle followed on the next cycle by a write to the same address of read data XOR mask. Read and write strobes are never high together, so a byte hit by two locations accumulates both flips.
- R12: A syndrome word presented with its valid bit yields, one cycle later, the low syndrome from word bits 11:0 and the high syndrome from word bits 27:16 with a valid bit. All other word bits are ignored.
- R13: A location count above 4 is reported as a failure with no memory access.
- R14: After reset the block is idle: busy, done, read and write strobes are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a correction pass (taken when idle) |
| ecc_flag | input | 1 | ECC-error qualifier; correction runs only when high |
| err_count | input | 3 | Number of error locations supplied |
| err_pos | input | 48 | Four packed 12-bit symbol positions, entry 0 in bits 11:0 |
| err_pat | input | 48 | Four packed 12-bit error values, entry 0 in bits 11:0 |
| mem_rd | output | 1 | Buffer read strobe (data returns next cycle) |
| mem_wr | output | 1 | Buffer write strobe |
| mem_addr | output | 12 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, one cycle after mem_rd |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| corr_count | output | 3 | Symbols repaired, valid with done |
| fail | output | 1 | Uncorrectable, valid with done |
| syn_in_valid | input | 1 | Syndrome status word valid |
| syn_in_word | input | 32 | Syndrome status word |
| syn_out_valid | output | 1 | Unpacked syndromes valid |
| syn_out_lo | output | 12 | Syndrome from word bits 11:0 |
| syn_out_hi | output | 12 | Syndrome from word bits 27:16 |

## Verification
The checker watches the memory handshake on every cycle. It confirms that no write comes without a read of the same address one cycle earlier, that read and write strobes never overlap, and that every access stays inside the page. It also checks the one-cycle done pulse, the zero count on failure, the immediate reply with the qualifier low, idle silence and the syndrome split latency. What it cannot see is whether the right bytes received the right nibbles. Only the directed scenarios show that, by comparing the whole buffer model against expected contents after odd, even, zero, boundary, spare-area, overlapping and failing locations.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_MAP  = 3'd1,
      ST_RD_A = 3'd2,
      ST_WR_A = 3'd3,
      ST_RD_B = 3'd4,
      ST_WR_B = 3'd5,
      ST_FIN  = 3'd6
   } fix_state_t;

   // nibble placement helpers for a 12-bit symbol value
   function automatic logic [7:0] hi_byte(input logic [11:0] v);
      return v[11:4];
   endfunction

   function automatic logic [7:0] lo_nib_up(input logic [11:0] v);
      return {v[3:0], 4'h0};
   endfunction

   function automatic logic [7:0] top_nib_dn(input logic [11:0] v);
      return {4'h0, v[11:8]};
   endfunction
endpackage

// File: rtl/rs_syn_split.sv
module rs_syn_split #(
   parameter int WORD_W  = 32,
   parameter int SYM_W   = 12,
   parameter int HI_LSB  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   output logic [SYM_W-1:0]  out_lo,
   output logic [SYM_W-1:0]  out_hi
);
   generate
      if (HI_LSB + SYM_W > WORD_W) begin : g_bad
         $error("syndrome fields exceed word width");
      end
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_lo    <= '0;
               out_hi    <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_lo <= in_word[SYM_W-1:0];
                  out_hi <= in_word[HI_LSB +: SYM_W];
               end
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid;
         assign out_lo    = in_word[SYM_W-1:0];
         assign out_hi    = in_word[HI_LSB +: SYM_W];
      end
   endgenerate
endmodule

// File: rtl/rs_sym_map.sv
module rs_sym_map #(
   parameter int POS_W    = 12,
   parameter int SYM_W    = 12,
   parameter int ADDR_W   = 12,
   parameter int LAST_POS = 1374
) (
   input  logic [POS_W-1:0]  pos,
   input  logic [SYM_W-1:0]  pat,
   output logic              bad,
   output logic              two,
   output logic [ADDR_W-1:0] addr_a,
   output logic [7:0]        mask_a,
   output logic [ADDR_W-1:0] addr_b,
   output logic [7:0]        mask_b
);
   import rs_fix_pkg::*;

   localparam logic [POS_W-1:0] LAST_P = POS_W'(LAST_POS);

   generate
      if (SYM_W != 12) begin : g_bad_sym
         $error("byte-and-a-half packing needs 12-bit symbols");
      end
   endgenerate

   logic [POS_W+1:0] tri3;
   logic [POS_W:0]   base;

   assign tri3 = {2'b00, pos} + {1'b0, pos, 1'b0};
   assign base = tri3[POS_W+1:1];

   always_comb begin
      bad    = 1'b0;
      two    = 1'b1;
      addr_a = ADDR_W'(base);
      mask_a = hi_byte(pat);
      addr_b = ADDR_W'(base + {{POS_W{1'b0}}, 1'b1});
      mask_b = lo_nib_up(pat);
      if (pos > LAST_P) begin
         bad = 1'b1;
      end else if (pos == '0) begin
         bad    = |pat[11:8];
         two    = 1'b0;
         addr_a = '0;
         mask_a = pat[7:0];
      end else if (!pos[0]) begin
         addr_a = ADDR_W'(base - {{POS_W{1'b0}}, 1'b1});
         mask_a = top_nib_dn(pat);
         addr_b = ADDR_W'(base);
         mask_b = pat[7:0];
      end
   end
endmodule

// File: rtl/rs_fix_seq.sv
module rs_fix_seq #(
   parameter int MAX_ERR = 4,
   parameter int POS_W   = 12,
   parameter int SYM_W   = 12,
   parameter int ADDR_W  = 12,
   parameter int CNT_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     ecc_flag,
   input  logic [CNT_W-1:0]         err_count,
   input  logic [MAX_ERR*POS_W-1:0] err_pos,
   input  logic [MAX_ERR*SYM_W-1:0] err_pat,
   output logic [POS_W-1:0]         cur_pos,
   output logic [SYM_W-1:0]         cur_pat,
   input  logic                     map_bad,
   input  logic                     map_two,
   input  logic [ADDR_W-1:0]        map_addr_a,
   input  logic [7:0]               map_mask_a,
   input  logic [ADDR_W-1:0]        map_addr_b,
   input  logic [7:0]               map_mask_b,
   output logic                     mem_rd,
   output logic                     mem_wr,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [7:0]               mem_wdata,
   input  logic [7:0]               mem_rdata,
   output logic                     busy,
   output logic                     done,
   output logic [CNT_W-1:0]         corr_count,
   output logic                     fail
);
   import rs_fix_pkg::*;

   localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ERR);

   fix_state_t        state;
   logic [POS_W-1:0]  pos_q [MAX_ERR];
   logic [SYM_W-1:0]  pat_q [MAX_ERR];
   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  n_q;
   logic              fail_q;
   logic              two_q;
   logic [ADDR_W-1:0] addr_a_q, addr_b_q;
   logic [7:0]        mask_a_q, mask_b_q;
   logic              last_pair;

   assign cur_pos   = pos_q[idx];
   assign cur_pat   = pat_q[idx];
   assign last_pair = (CNT_W'(idx) + {{(CNT_W-1){1'b0}}, 1'b1}) == n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         n_q      <= '0;
         fail_q   <= 1'b0;
         two_q    <= 1'b0;
         addr_a_q <= '0;
         addr_b_q <= '0;
         mask_a_q <= '0;
         mask_b_q <= '0;
         for (int i = 0; i < MAX_ERR; i++) begin
            pos_q[i] <= '0;
            pat_q[i] <= '0;
         end
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               idx    <= '0;
               fail_q <= 1'b0;
               n_q    <= ecc_flag ? err_count : '0;
               for (int i = 0; i < MAX_ERR; i++) begin
                  pos_q[i] <= err_pos[i*POS_W +: POS_W];
                  pat_q[i] <= err_pat[i*SYM_W +: SYM_W];
               end
               if (!ecc_flag || err_count == '0) begin
                  state <= ST_FIN;
               end else if (err_count > MAX_C) begin
                  fail_q <= 1'b1;
                  state  <= ST_FIN;
               end else begin
                  state <= ST_MAP;
               end
            end
            ST_MAP: begin
               if (fail_q || map_bad) begin
                  fail_q <= 1'b1;
                  if (last_pair) state <= ST_FIN;
                  else begin
                     idx   <= idx + 1'b1;
                     state <= ST_MAP;
                  end
               end else begin
                  two_q    <= map_two;
                  addr_a_q <= map_addr_a;
                  addr_b_q <= map_addr_b;
                  mask_a_q <= map_mask_a;
                  mask_b_q <= map_mask_b;
                  state    <= ST_RD_A;
               end
            end
            ST_RD_A: state <= ST_WR_A;
            ST_WR_A: begin
               if (two_q) state <= ST_RD_B;
               else if (last_pair) state <= ST_FIN;
               else begin
                  idx   <= idx + 1'b1;
                  state <= ST_MAP;
               end
            end
            ST_RD_B: state <= ST_WR_B;
            ST_WR_B: begin
               if (last_pair) state <= ST_FIN;
               else begin
                  idx   <= idx + 1'b1;
                  state <= ST_MAP;
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_rd    = (state == ST_RD_A) || (state == ST_RD_B);
      mem_wr    = (state == ST_WR_A) || (state == ST_WR_B);
      mem_addr  = ((state == ST_RD_B) || (state == ST_WR_B)) ? addr_b_q : addr_a_q;
      mem_wdata = mem_rdata ^ ((state == ST_WR_B) ? mask_b_q : mask_a_q);
   end

   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_FIN);
   assign fail       = done && fail_q;
   assign corr_count = (done && !fail_q) ? n_q : '0;
endmodule

// File: rtl/rs_symbol_fixer.sv
module rs_symbol_fixer #(
   parameter int  MAX_ERR     = 4,
   parameter int  POS_W       = 12,
   parameter int  SYM_W       = 12,
   parameter int  DATA_BYTES  = 2048,
   parameter int  SPARE_BYTES = 64,
   parameter int  LAST_POS    = 1374,
   parameter int  SYN_WORD_W  = 32,
   parameter int  SYN_HI_LSB  = 16,
   parameter bit  SYN_REG     = 1'b1
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        start,
   input  logic                                        ecc_flag,
   input  logic [$clog2(MAX_ERR+1)-1:0]                err_count,
   input  logic [MAX_ERR*POS_W-1:0]                    err_pos,
   input  logic [MAX_ERR*SYM_W-1:0]                    err_pat,
   output logic                                        mem_rd,
   output logic                                        mem_wr,
   output logic [$clog2(DATA_BYTES+SPARE_BYTES)-1:0]   mem_addr,
   output logic [7:0]                                  mem_wdata,
   input  logic [7:0]                                  mem_rdata,
   output logic                                        busy,
   output logic                                        done,
   output logic [$clog2(MAX_ERR+1)-1:0]                corr_count,
   output logic                                        fail,
   input  logic                                        syn_in_valid,
   input  logic [SYN_WORD_W-1:0]                       syn_in_word,
   output logic                                        syn_out_valid,
   output logic [SYM_W-1:0]                            syn_out_lo,
   output logic [SYM_W-1:0]                            syn_out_hi
);
   localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
   localparam int ADDR_W     = $clog2(PAGE_BYTES);
   localparam int CNT_W      = $clog2(MAX_ERR + 1);

   generate
      if ((LAST_POS * 3) / 2 >= PAGE_BYTES) begin : g_chk_page
         $error("highest position would address past the page");
      end
      if (LAST_POS >= (1 << POS_W)) begin : g_chk_pos
         $error("position field too narrow for highest position");
      end
      if (MAX_ERR < 1) begin : g_chk_cnt
         $error("at least one error location is required");
      end
   endgenerate

   logic [POS_W-1:0]  cur_pos;
   logic [SYM_W-1:0]  cur_pat;
   logic              map_bad, map_two;
   logic [ADDR_W-1:0] map_addr_a, map_addr_b;
   logic [7:0]        map_mask_a, map_mask_b;

   rs_sym_map #(
      .POS_W(POS_W), .SYM_W(SYM_W), .ADDR_W(ADDR_W), .LAST_POS(LAST_POS)
   ) u_map (
      .pos(cur_pos), .pat(cur_pat), .bad(map_bad), .two(map_two),
      .addr_a(map_addr_a), .mask_a(map_mask_a),
      .addr_b(map_addr_b), .mask_b(map_mask_b)
   );

   rs_fix_seq #(
      .MAX_ERR(MAX_ERR), .POS_W(POS_W), .SYM_W(SYM_W),
      .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ecc_flag(ecc_flag),
      .err_count(err_count), .err_pos(err_pos), .err_pat(err_pat),
      .cur_pos(cur_pos), .cur_pat(cur_pat),
      .map_bad(map_bad), .map_two(map_two),
      .map_addr_a(map_addr_a), .map_mask_a(map_mask_a),
      .map_addr_b(map_addr_b), .map_mask_b(map_mask_b),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .corr_count(corr_count), .fail(fail)
   );

   rs_syn_split #(
      .WORD_W(SYN_WORD_W), .SYM_W(SYM_W), .HI_LSB(SYN_HI_LSB), .REG_OUT(SYN_REG)
   ) u_syn (
      .clk(clk), .rst_n(rst_n), .in_valid(syn_in_valid), .in_word(syn_in_word),
      .out_valid(syn_out_valid), .out_lo(syn_out_lo), .out_hi(syn_out_hi)
   );
endmodule

// File: rtl/rs_symbol_fixer_chk.sv
module rs_symbol_fixer_chk #(
   parameter int PAGE_BYTES = 2112,
   parameter int ADDR_W     = 12,
   parameter int CNT_W      = 3,
   parameter int MAX_ERR    = 4,
   parameter int SYM_W      = 12,
   parameter int WORD_W     = 32,
   parameter int HI_LSB     = 16,
   parameter bit SYN_REG    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              ecc_flag,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy,
   input logic              done,
   input logic [CNT_W-1:0]  corr_count,
   input logic              fail,
   input logic              syn_in_valid,
   input logic [WORD_W-1:0] syn_in_word,
   input logic              syn_out_valid,
   input logic [SYM_W-1:0]  syn_out_lo,
   input logic [SYM_W-1:0]  syn_out_hi
);
   localparam logic [ADDR_W:0] PAGE_LIM = (ADDR_W+1)'(PAGE_BYTES);
   localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_ERR);

   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R11
   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && $past(mem_addr) == mem_addr)); // R11
   AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> ({1'b0, mem_addr} < PAGE_LIM)); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (corr_count <= MAX_C)); // R9
   AST_FAIL_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> (corr_count == '0)); // R8
   AST_DISABLED_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !ecc_flag) |=> (done && !fail && corr_count == '0)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_rd && !mem_wr && !done)); // R14

   generate
      if (SYN_REG) begin : g_syn_reg
         AST_SYN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            syn_in_valid |=> syn_out_valid); // R12
         AST_SYN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
            syn_out_valid |-> (syn_out_lo == $past(syn_in_word[SYM_W-1:0]) &&
                               syn_out_hi == $past(syn_in_word[HI_LSB +: SYM_W]))); // R12
      end
   endgenerate
endmodule

bind rs_symbol_fixer rs_symbol_fixer_chk #(
   .PAGE_BYTES(DATA_BYTES + SPARE_BYTES),
   .ADDR_W($clog2(DATA_BYTES + SPARE_BYTES)),
   .CNT_W($clog2(MAX_ERR + 1)),
   .MAX_ERR(MAX_ERR),
   .SYM_W(SYM_W),
   .WORD_W(SYN_WORD_W),
   .HI_LSB(SYN_HI_LSB),
   .SYN_REG(SYN_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .ecc_flag(ecc_flag),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
   .busy(busy), .done(done), .corr_count(corr_count), .fail(fail),
   .syn_in_valid(syn_in_valid), .syn_in_word(syn_in_word),
   .syn_out_valid(syn_out_valid), .syn_out_lo(syn_out_lo), .syn_out_hi(syn_out_hi)
);

// File: tb/rs_symbol_fixer_test.sv
`timescale 1ns/1ps
module rs_symbol_fixer_test;
   localparam int PAGE = 2112;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ecc_flag = 1'b0;
   logic [2:0]  err_count = '0;
   logic [47:0] err_pos = '0;
   logic [47:0] err_pat = '0;
   logic        mem_rd, mem_wr;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        busy, done, fail;
   logic [2:0]  corr_count;
   logic        syn_in_valid = 1'b0;
   logic [31:0] syn_in_word = '0;
   logic        syn_out_valid;
   logic [11:0] syn_out_lo, syn_out_hi;

   logic [7:0]  ram [PAGE];
   logic [7:0]  expv [PAGE];
   int          wr_total = 0;
   int          rd_total = 0;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   int          got_cnt;
   bit          got_fail;
   int          got_wr;
   int          got_rd;

   always #2 clk = ~clk;

   rs_symbol_fixer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ecc_flag(ecc_flag),
      .err_count(err_count), .err_pos(err_pos), .err_pat(err_pat),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .corr_count(corr_count), .fail(fail),
      .syn_in_valid(syn_in_valid), .syn_in_word(syn_in_word),
      .syn_out_valid(syn_out_valid), .syn_out_lo(syn_out_lo), .syn_out_hi(syn_out_hi)
   );

   always_ff @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= ram[mem_addr];
         rd_total  <= rd_total + 1;
      end
      if (mem_wr) begin
         ram[mem_addr] <= mem_wdata;
         wr_total      <= wr_total + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fill_ram();
      for (int i = 0; i < PAGE; i++) begin
         ram[i]  = 8'((i * 37 + 11) & 255);
         expv[i] = ram[i];
      end
   endtask

   // expected effect of one location, from the R1/R3/R4 rules
   task automatic exp_fix(input int p, input int v);
      int b;
      if (p == 0) begin
         expv[0] ^= 8'(v & 255);
      end else begin
         b = (3 * p) / 2;
         if (p % 2 == 1) begin
            expv[b]   ^= 8'((v >> 4) & 255);
            expv[b+1] ^= 8'((v & 15) << 4);
         end else begin
            expv[b-1] ^= 8'((v >> 8) & 15);
            expv[b]   ^= 8'(v & 255);
         end
      end
   endtask

   task automatic cmp_ram(input string req);
      int bad = 0;
      int first = -1;
      for (int i = 0; i < PAGE; i++)
         if (ram[i] !== expv[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      if (first < 0) check(1'b1, req, 0, 0);
      else check(1'b0, req, int'(ram[first]), int'(expv[first]));
   endtask

   task automatic run(input bit flag, input int n, input logic [47:0] pv, input logic [47:0] tv);
      int wr0, rd0;
      bit seen = 1'b0;
      wr0 = wr_total;
      rd0 = rd_total;
      @(negedge clk);
      ecc_flag  = flag;
      err_count = 3'(n);
      err_pos   = pv;
      err_pat   = tv;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 200 && !seen; c++) begin
         if (done) begin
            seen     = 1'b1;
            got_cnt  = int'(corr_count);
            got_fail = fail;
         end else @(negedge clk);
      end
      if (!seen) check(1'b0, "watchdog done", 0, 1);
      @(negedge clk);
      got_wr = wr_total - wr0;
      got_rd = rd_total - rd0;
   endtask

   task automatic t_reset();
      check(!busy && !done && !mem_rd && !mem_wr, "R14 idle after reset",
            {busy, done, mem_rd, mem_wr}, 0);
   endtask

   task automatic t_pos0();
      fill_ram();
      exp_fix(0, 12'h0A5);
      run(1'b1, 1, 48'h000, 48'h0A5);
      check(got_cnt == 1 && !got_fail, "R1 pos0 count", got_cnt, 1);
      cmp_ram("R1 pos0 bytes");
   endtask

   task automatic t_pos0_bad();
      fill_ram();
      run(1'b1, 1, 48'h000, 48'h1A5);
      check(got_fail && got_cnt == 0, "R2 pos0 high bits fail", got_fail, 1);
      check(got_wr == 0, "R2 no write", got_wr, 0);
      cmp_ram("R2 buffer untouched");
   endtask

   task automatic t_odd();
      fill_ram();
      exp_fix(3, 12'hABC);
      run(1'b1, 1, 48'd3, 48'hABC);
      check(got_cnt == 1 && !got_fail, "R3 odd count", got_cnt, 1);
      check(ram[4] == expv[4] && ram[5] == expv[5], "R3 odd bytes 4,5", int'(ram[5]), int'(expv[5]));
      cmp_ram("R3 odd page");
   endtask

   task automatic t_even();
      fill_ram();
      exp_fix(10, 12'h5E7);
      run(1'b1, 1, 48'd10, 48'h5E7);
      check(got_cnt == 1 && !got_fail, "R4 even count", got_cnt, 1);
      cmp_ram("R4 even page");
   endtask

   task automatic t_boundary();
      fill_ram();
      exp_fix(1365, 12'hF3C);
      run(1'b1, 1, 48'd1365, 48'hF3C);
      check(ram[2047] == expv[2047] && ram[2048] == expv[2048],
            "R5 straddle bytes", int'(ram[2048]), int'(expv[2048]));
      cmp_ram("R5 straddle page");
   endtask

   task automatic t_spare();
      logic [47:0] pv, tv;
      fill_ram();
      pv = {12'd0, 12'd1374, 12'd1367, 12'd1366};
      tv = {12'd0, 12'h9D2, 12'h4B1, 12'h7C3};
      exp_fix(1366, 12'h7C3);
      exp_fix(1367, 12'h4B1);
      exp_fix(1374, 12'h9D2);
      run(1'b1, 3, pv, tv);
      check(got_cnt == 3 && !got_fail, "R6 spare count", got_cnt, 3);
      check(ram[2060] == expv[2060] && ram[2061] == expv[2061],
            "R6 last position bytes", int'(ram[2061]), int'(expv[2061]));
      cmp_ram("R6 spare page");
   endtask

   task automatic t_multi();
      logic [47:0] pv, tv;
      fill_ram();
      pv = {12'd700, 12'd2, 12'd1, 12'd0};
      tv = {12'h123, 12'hF0F, 12'h3C5, 12'h0FF};
      exp_fix(0, 12'h0FF);
      exp_fix(1, 12'h3C5);
      exp_fix(2, 12'hF0F);
      exp_fix(700, 12'h123);
      run(1'b1, 4, pv, tv);
      check(got_cnt == 4 && !got_fail, "R9 four locations count", got_cnt, 4);
      check(got_wr == 7 && got_rd == 7, "R11 one read and write per byte", got_wr, 7);
      cmp_ram("R11 overlapping byte accumulates");
   endtask

   task automatic t_far();
      fill_ram();
      run(1'b1, 1, 48'd1375, 48'h111);
      check(got_fail && got_cnt == 0, "R7 position 1375 fails", got_fail, 1);
      check(got_wr == 0, "R7 no write", got_wr, 0);
   endtask

   task automatic t_drain();
      logic [47:0] pv, tv;
      fill_ram();
      pv = {12'd0, 12'd7, 12'd2000, 12'd5};
      tv = {12'd0, 12'hEEE, 12'h222, 12'h6A9};
      exp_fix(5, 12'h6A9);
      run(1'b1, 3, pv, tv);
      check(got_fail && got_cnt == 0, "R8 fail count zero", got_cnt, 0);
      check(got_wr == 2, "R8 only first location written", got_wr, 2);
      cmp_ram("R8 later location dropped");
   endtask

   task automatic t_disabled();
      int t0;
      bit hit = 1'b0;
      fill_ram();
      t0 = wr_total + rd_total;
      @(negedge clk);
      ecc_flag  = 1'b0;
      err_count = 3'd1;
      err_pos   = 48'd3;
      err_pat   = 48'hFFF;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      hit   = done && !fail && corr_count == 0;
      check(hit, "R10 immediate zero result", {done, fail}, 2);
      @(negedge clk);
      check((wr_total + rd_total) == t0, "R10 no memory access", wr_total + rd_total - t0, 0);
      cmp_ram("R10 buffer untouched");
   endtask

   task automatic t_too_many();
      fill_ram();
      run(1'b1, 5, 48'd3, 48'h111);
      check(got_fail && got_cnt == 0, "R13 count above four fails", got_fail, 1);
      check(got_wr == 0 && got_rd == 0, "R13 no access", got_wr + got_rd, 0);
   endtask

   task automatic t_syn();
      @(negedge clk);
      syn_in_valid = 1'b1;
      syn_in_word  = 32'hFABC_F123;
      @(negedge clk);
      syn_in_valid = 1'b0;
      check(syn_out_valid, "R12 valid after one cycle", syn_out_valid, 1);
      check(syn_out_lo == 12'h123, "R12 low syndrome", syn_out_lo, 12'h123);
      check(syn_out_hi == 12'hABC, "R12 high syndrome", syn_out_hi, 12'hABC);
      @(negedge clk);
      check(!syn_out_valid, "R12 valid drops", syn_out_valid, 0);
   endtask

   initial begin
      fill_ram();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pos0();
      t_pos0_bad();
      t_odd();
      t_even();
      t_boundary();
      t_spare();
      t_multi();
      t_far();
      t_drain();
      t_disabled();
      t_too_many();
      t_syn();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(4 * 100000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule